// File: doc/BRIEF.md
# Parallel NOR Flash Program and Erase Controller

This block is the host-side engine for a parallel NOR flash bus. A client hands it one request at a time over a valid/ready handshake: program one word, erase the whole chip, or erase one sector. The engine writes the unlock and command cycles the flash expects, then decides completion by reading status back from the target location instead of waiting a fixed time.

Two polling methods are offered, picked per request. With data-complement polling, bit 7 of a status read is compared with bit 7 of the value the location should finally hold. With toggle polling, two back-to-back reads are compared on bit 6. Both treat a set bit 5 (the flash's time-limit flag) as grounds for one confirming re-check, never as an immediate failure. Erases end with a read of the target that must return all ones. Any failure, including a polling watchdog timeout, makes the engine write the flash's reset command before it reports the result.

Every bus access is a separate read or write cycle with its own chip-enable setup time and strobe width, both set by parameters.

Top module: `nor_prog_engine`

## Requirements
- R1: A program request (`req_op` = 0) issues four writes in this order: 0xAA at 0x555, 0x55 at 0x2AA, 0xA0 at 0x555, then `req_data` at `req_addr`.
- R2: A chip erase request (`req_op` = 1, and also 3) issues six writes: 0xAA@0x555, 0x55@0x2AA, 0x80@0x555, 0xAA@0x555, 0x55@0x2AA, 0x10@0x555.
- R3: A sector erase request (`req_op` = 2) issues the same first five writes as R2, and its sixth write is 0x30 at `req_addr`.
- R4: Each bus cycle pulls `fl_ce_n` low SETUP_CYC cycles before its strobe. The strobe (`fl_we_n` for writes, `fl_oe_n` for reads) stays low for STROBE_CYC cycles. The two strobes are never low together, and neither is low while `fl_ce_n` is high.
- R5: With `req_toggle` = 0, the engine reads `req_addr` repeatedly. Polling ends successfully on the first read whose bit 7 equals the expected bit: bit 7 of `req_data` for a program, 1 for an erase.
- R6: In that mode, a read with bit 7 wrong and bit 5 set is followed by exactly one re-read. The request succeeds if the re-read's bit 7 matches and fails if it does not.
- R7: With `req_toggle` = 1, the engine reads `req_addr` in pairs. Polling ends successfully when bit 6 is the same in both reads of a pair.
- R8: In toggle mode, a pair whose bit 6 differs, with bit 5 set in its second read, is followed by exactly one more pair. The request fails if bit 6 still differs in that pair.
- R9: After polling completes for an erase, the engine reads `req_addr` once more. It reports success only if that read returns all ones; any other value is a failure.
- R10: If polling has run for POLL_LIMIT clock cycles without completing, the next evaluated read ends the request as a failure.
- R11: On any failure, the engine writes 0xF0 at address 0 as its last bus cycle, before `done_valid` rises with `done_fail` = 1.
- R12: `req_ready` is high exactly when the engine is idle and a request is taken on `req_valid` && `req_ready`. `done_valid` is a one-cycle pulse, issued in the first cycle `req_ready` is high again. After reset, `req_ready` = 1, `done_valid` = 0 and all bus strobes and `fl_ce_n` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle, request taken when valid |
| req_op | input | 2 | 0 program, 1 chip erase, 2 sector erase, 3 as chip erase |
| req_addr | input | AW | Target word / sector address, also the polling address |
| req_data | input | DW | Program data |
| req_toggle | input | 1 | 0 data-complement polling, 1 toggle polling |
| done_valid | output | 1 | One-cycle result pulse |
| done_fail | output | 1 | Result of the request, valid with done_valid |
| fl_addr | output | AW | Flash address bus |
| fl_wdata | output | DW | Flash write data |
| fl_rdata | input | DW | Flash read data |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_we_n | output | 1 | Flash write strobe, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |

## Verification
A bus cycle that starts at clock edge E lowers `fl_ce_n` at E and its strobe at E+SETUP_CYC, and raises both at E+SETUP_CYC+STROBE_CYC. Its captured read reaches the controller two edges after that, so cycles follow one another every SETUP_CYC+STROBE_CYC+3 clocks. `done_valid` rises two edges after the strobe of the final cycle of a request (the last poll or verify read, or the 0xF0 write) goes high. The bench samples everything on the falling clock edge and measures strobe setup and width by counting cycles between those samples. It pairs each write-strobe rising edge with the next entry in an expected-write queue, and it pops an expected result only on a sampled `done_valid`, checking `req_ready` in that same sample.

// File: rtl/nor_pkg.sv
package nor_pkg;

  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_CHIP = 2'd1,
    OP_SECT = 2'd2,
    OP_RSVD = 2'd3
  } op_e;

  localparam logic [11:0] UNLK_ADDR_A = 12'h555;
  localparam logic [11:0] UNLK_ADDR_B = 12'h2AA;
  localparam logic [7:0]  KEY_A       = 8'hAA;
  localparam logic [7:0]  KEY_B       = 8'h55;
  localparam logic [7:0]  CMD_PROG    = 8'hA0;
  localparam logic [7:0]  CMD_ERSU    = 8'h80;
  localparam logic [7:0]  CMD_CHIP    = 8'h10;
  localparam logic [7:0]  CMD_SECT    = 8'h30;
  localparam logic [7:0]  CMD_RST     = 8'hF0;

  // status bit positions returned by the flash while it is busy
  localparam int ST_DONE_BIT = 7;
  localparam int ST_TOG_BIT  = 6;
  localparam int ST_ERR_BIT  = 5;

  typedef struct packed {
    logic [11:0] a;
    logic [7:0]  d;
    logic        use_tgt;   // address comes from the request
    logic        use_dat;   // data comes from the request
  } cmd_t;

  function automatic logic [2:0] seq_last(op_e op);
    return (op == OP_PROG) ? 3'd3 : 3'd5;
  endfunction

  function automatic cmd_t cmd_at(op_e op, logic [2:0] step);
    cmd_t c;
    c   = '0;
    c.a = UNLK_ADDR_A;
    case (step)
      3'd0: c.d = KEY_A;
      3'd1: begin c.a = UNLK_ADDR_B; c.d = KEY_B; end
      3'd2: c.d = (op == OP_PROG) ? CMD_PROG : CMD_ERSU;
      3'd3: begin
        if (op == OP_PROG) begin c.use_tgt = 1'b1; c.use_dat = 1'b1; end
        else c.d = KEY_A;
      end
      3'd4: begin c.a = UNLK_ADDR_B; c.d = KEY_B; end
      default: begin
        if (op == OP_SECT) begin c.use_tgt = 1'b1; c.d = CMD_SECT; end
        else c.d = CMD_CHIP;
      end
    endcase
    return c;
  endfunction

endpackage

// File: rtl/nor_bus_cycle.sv
module nor_bus_cycle #(
  parameter int AW         = 20,
  parameter int DW         = 8,
  parameter int SETUP_CYC  = 2,
  parameter int STROBE_CYC = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic [AW-1:0] fl_addr,
  output logic [DW-1:0] fl_wdata,
  input  logic [DW-1:0] fl_rdata,
  output logic          fl_ce_n,
  output logic          fl_we_n,
  output logic          fl_oe_n
);

  localparam int CNT_MAX = (SETUP_CYC > STROBE_CYC) ? SETUP_CYC : STROBE_CYC;
  localparam int CW      = $clog2(CNT_MAX + 1);

  typedef enum logic [1:0] {B_IDLE, B_SETUP, B_STROBE, B_RECOV} bst_e;

  bst_e          st;
  logic [CW-1:0] cnt;
  logic          is_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= B_IDLE;
      cnt      <= '0;
      is_wr    <= 1'b0;
      done     <= 1'b0;
      rdata    <= '0;
      fl_addr  <= '0;
      fl_wdata <= '0;
      fl_ce_n  <= 1'b1;
      fl_we_n  <= 1'b1;
      fl_oe_n  <= 1'b1;
    end else begin
      done <= 1'b0;
      case (st)
        B_IDLE: if (start) begin
          fl_addr  <= addr;
          fl_wdata <= wdata;
          is_wr    <= we;
          fl_ce_n  <= 1'b0;
          cnt      <= CW'(SETUP_CYC - 1);
          st       <= B_SETUP;
        end
        B_SETUP: begin
          if (cnt == '0) begin
            cnt <= CW'(STROBE_CYC - 1);
            st  <= B_STROBE;
            if (is_wr) fl_we_n <= 1'b0;
            else       fl_oe_n <= 1'b0;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        B_STROBE: begin
          if (cnt == '0) begin
            fl_we_n <= 1'b1;
            fl_oe_n <= 1'b1;
            fl_ce_n <= 1'b1;
            if (!is_wr) rdata <= fl_rdata;
            st <= B_RECOV;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          done <= 1'b1;
          st   <= B_IDLE;
        end
      endcase
    end
  end

  // R4: never both strobes at once
  a_r4_single_strobe: assert property (@(posedge clk) disable iff (rst)
    !(!fl_we_n && !fl_oe_n));

  // R4: strobes only inside an enabled cycle
  a_r4_strobe_in_ce: assert property (@(posedge clk) disable iff (rst)
    (!fl_we_n || !fl_oe_n) |-> !fl_ce_n);

  // R4: address held for the whole enabled cycle
  a_r4_addr_stable: assert property (@(posedge clk) disable iff (rst)
    (!fl_ce_n && $past(!fl_ce_n)) |-> $stable(fl_addr));

endmodule

// File: rtl/nor_poll_watchdog.sv
module nor_poll_watchdog #(
  parameter int LIMIT = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic run,
  output logic expired
);

  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear)                  cnt <= '0;
    else if (run && cnt != CW'(LIMIT)) cnt <= cnt + 1'b1;
  end

  assign expired = (cnt == CW'(LIMIT));

  // R10: once expired while polling, it stays expired until cleared
  a_r10_wd_sticky: assert property (@(posedge clk) disable iff (rst)
    (expired && !clear) |=> expired);

endmodule

// File: rtl/nor_prog_engine.sv
module nor_prog_engine
  import nor_pkg::*;
#(
  parameter int AW         = 20,
  parameter int DW         = 8,
  parameter int SETUP_CYC  = 2,
  parameter int STROBE_CYC = 3,
  parameter int POLL_LIMIT = 4096
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  input  logic          req_toggle,
  output logic          done_valid,
  output logic          done_fail,
  output logic [AW-1:0] fl_addr,
  output logic [DW-1:0] fl_wdata,
  input  logic [DW-1:0] fl_rdata,
  output logic          fl_ce_n,
  output logic          fl_we_n,
  output logic          fl_oe_n
);

  typedef enum logic [2:0] {
    T_IDLE, T_CMD, T_POLL_A, T_POLL_B, T_CONF_A, T_CONF_B, T_VERIFY, T_RESET
  } tst_e;

  tst_e          st, nx_st;
  logic          pend;
  logic [2:0]    step;
  op_e           op_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic          tog_q;
  logic          rd_a6;
  logic [DW-1:0] last_wr;

  logic          bus_start, bus_we, bus_done;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;

  logic          wd_hit, in_poll;
  logic          cmplt, ok, bad, latch_a, exp7, match7, same6;
  cmd_t          cmd;

  assign cmd       = cmd_at(op_q, step);
  assign in_poll   = (st == T_POLL_A) || (st == T_POLL_B) ||
                     (st == T_CONF_A) || (st == T_CONF_B);
  assign exp7      = (op_q == OP_PROG) ? data_q[ST_DONE_BIT] : 1'b1;
  assign match7    = (bus_rdata[ST_DONE_BIT] == exp7);
  assign same6     = (bus_rdata[ST_TOG_BIT] == rd_a6);
  assign req_ready = (st == T_IDLE);
  assign bus_start = (st != T_IDLE) && !pend;

  // bus request mux
  always_comb begin
    bus_we    = 1'b0;
    bus_addr  = addr_q;
    bus_wdata = '0;
    if (st == T_CMD) begin
      bus_we    = 1'b1;
      bus_addr  = cmd.use_tgt ? addr_q : AW'(cmd.a);
      bus_wdata = cmd.use_dat ? data_q : DW'(cmd.d);
    end else if (st == T_RESET) begin
      bus_we    = 1'b1;
      bus_addr  = '0;
      bus_wdata = DW'(CMD_RST);
    end
  end

  // status evaluation at the end of each bus cycle
  always_comb begin
    nx_st   = st;
    cmplt   = 1'b0;
    ok      = 1'b0;
    bad     = 1'b0;
    latch_a = 1'b0;
    if (bus_done) begin
      case (st)
        T_CMD:    if (step == seq_last(op_q)) nx_st = T_POLL_A;
        T_POLL_A: begin
          if (tog_q) begin
            latch_a = 1'b1;
            nx_st   = T_POLL_B;
          end else if (match7)                cmplt = 1'b1;
          else if (bus_rdata[ST_ERR_BIT])     nx_st = T_CONF_A;
        end
        T_POLL_B: begin
          if (same6)                          cmplt = 1'b1;
          else if (bus_rdata[ST_ERR_BIT])     nx_st = T_CONF_A;
          else                                nx_st = T_POLL_A;
        end
        T_CONF_A: begin
          if (tog_q) begin
            latch_a = 1'b1;
            nx_st   = T_CONF_B;
          end else if (match7) cmplt = 1'b1;
          else                 bad   = 1'b1;
        end
        T_CONF_B: begin
          if (same6) cmplt = 1'b1;
          else       bad   = 1'b1;
        end
        T_VERIFY: begin
          if (&bus_rdata) ok  = 1'b1;
          else            bad = 1'b1;
        end
        T_RESET:  nx_st = T_IDLE;
        default:  nx_st = st;
      endcase
      if (cmplt) begin
        if (op_q == OP_PROG) ok = 1'b1;
        else                 nx_st = T_VERIFY;
      end
      if (in_poll && wd_hit && !cmplt) bad = 1'b1;
      if (bad) nx_st = T_RESET;
      if (ok)  nx_st = T_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= T_IDLE;
      pend       <= 1'b0;
      step       <= '0;
      op_q       <= OP_PROG;
      addr_q     <= '0;
      data_q     <= '0;
      tog_q      <= 1'b0;
      rd_a6      <= 1'b0;
      last_wr    <= '0;
      done_valid <= 1'b0;
      done_fail  <= 1'b0;
    end else begin
      done_valid <= 1'b0;
      if (bus_start)     pend <= 1'b1;
      else if (bus_done) pend <= 1'b0;
      if (bus_start && bus_we) last_wr <= bus_wdata;
      if (latch_a) rd_a6 <= bus_rdata[ST_TOG_BIT];
      if (st == T_IDLE) begin
        if (req_valid) begin
          op_q   <= op_e'(req_op);
          addr_q <= req_addr;
          data_q <= req_data;
          tog_q  <= req_toggle;
          step   <= '0;
          st     <= T_CMD;
        end
      end else begin
        st <= nx_st;
        if (st == T_CMD && bus_done) step <= step + 3'd1;
        if (ok) begin
          done_valid <= 1'b1;
          done_fail  <= 1'b0;
        end
        if (st == T_RESET && bus_done) begin
          done_valid <= 1'b1;
          done_fail  <= 1'b1;
        end
      end
    end
  end

  nor_bus_cycle #(
    .AW(AW), .DW(DW), .SETUP_CYC(SETUP_CYC), .STROBE_CYC(STROBE_CYC)
  ) u_bus (
    .clk(clk), .rst(rst),
    .start(bus_start), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .done(bus_done), .rdata(bus_rdata),
    .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_rdata(fl_rdata),
    .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n)
  );

  nor_poll_watchdog #(.LIMIT(POLL_LIMIT)) u_wd (
    .clk(clk), .rst(rst),
    .clear(st == T_CMD), .run(in_poll),
    .expired(wd_hit)
  );

  // R12: result is a single-cycle pulse
  a_r12_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done_valid |=> !done_valid);

  // R11: a failure is reported only after the reset command went out
  a_r11_reset_before_fail: assert property (@(posedge clk) disable iff (rst)
    (done_valid && done_fail) |-> (last_wr == DW'(CMD_RST)));

  // R12: while ready the flash bus is quiet
  a_r12_ready_bus_quiet: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (fl_ce_n && fl_we_n && fl_oe_n));

endmodule

// File: tb/tb_nor_prog_engine.sv
module tb_nor_prog_engine;

  localparam int AW = 20, DW = 8, SETUP = 2, STROBE = 3, LIMIT = 200;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic          req_toggle = 1'b0;
  logic          done_valid, done_fail;
  logic [AW-1:0] fl_addr;
  logic [DW-1:0] fl_wdata;
  logic [DW-1:0] fl_rdata = '0;
  logic          fl_ce_n, fl_we_n, fl_oe_n;

  always #2 clk = ~clk;  // 250 MHz

  nor_prog_engine #(.AW(AW), .DW(DW), .SETUP_CYC(SETUP), .STROBE_CYC(STROBE),
                    .POLL_LIMIT(LIMIT)) dut (.*);

  int tests = 0, fails = 0;
  string cur_tag = "";

  task automatic chk(input bit good, input string req, input string what,
                     input int act, input int exp);
    tests++;
    if (!good) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // scoreboard queues
  typedef struct { logic [AW-1:0] a; logic [7:0] d; } wr_t;
  wr_t wr_q[$];
  bit  res_q[$];

  // responder knobs
  int         k_busy = 0, k_err = 0;
  logic [7:0] k_ready = 8'hFF;
  logic       k_tgt7 = 1'b1;
  logic [AW-1:0] exp_rd_addr = '0;
  int  busy_left = 0;
  bit  stuck = 0, arm_prog = 0, seen80 = 0, tog = 0;
  logic [7:0] ready_val = 8'hFF;

  // behavioural flash: writes
  always @(posedge fl_we_n) begin
    if (!rst) begin
      if (wr_q.size() == 0) chk(0, cur_tag, "unexpected write", int'(fl_wdata), 0);
      else begin
        wr_t e;
        e = wr_q.pop_front();
        chk(fl_addr == e.a, cur_tag, "write address", int'(fl_addr), int'(e.a));
        chk(fl_wdata == e.d, cur_tag, "write data", int'(fl_wdata), int'(e.d));
      end
      if (fl_wdata == 8'hF0) begin
        stuck = 0; busy_left = 0; arm_prog = 0; seen80 = 0;
      end else if (arm_prog) begin
        arm_prog = 0; busy_left = k_busy; stuck = (k_err == 2); tog = 0;
        ready_val = k_ready;
      end else if (fl_wdata == 8'hA0 && fl_addr == 20'h555) begin
        arm_prog = 1;
      end else if ((fl_wdata == 8'h10 || fl_wdata == 8'h30) && seen80) begin
        seen80 = 0; busy_left = k_busy; stuck = (k_err == 2); tog = 0;
        ready_val = k_ready;
      end else if (fl_wdata == 8'h80) begin
        seen80 = 1;
      end
    end
  end

  // behavioural flash: reads return status while busy
  always @(negedge fl_oe_n) begin
    if (!rst) begin
      chk(fl_addr == exp_rd_addr, "R5", "poll address", int'(fl_addr), int'(exp_rd_addr));
      if (stuck) begin
        fl_rdata = {~k_tgt7, tog, 1'b1, 5'b0};
        tog = ~tog;
      end else if (busy_left > 0) begin
        fl_rdata = {~k_tgt7, tog, (k_err == 1 && busy_left == 1), 5'b0};
        tog = ~tog;
        busy_left--;
      end else begin
        fl_rdata = ready_val;
      end
    end
  end

  // bus timing monitor (R4)
  int  cyc = 0, ce_at = 0, str_at = 0;
  logic p_ce = 1'b1, p_str = 1'b0;
  always @(posedge clk) cyc++;
  always @(negedge clk) begin
    if (!rst) begin
      logic s;
      s = !fl_we_n || !fl_oe_n;
      chk(!(!fl_we_n && !fl_oe_n), "R4", "both strobes low", 1, 0);
      if (p_ce && !fl_ce_n) ce_at = cyc;
      if (!p_str && s) begin
        str_at = cyc;
        chk(cyc - ce_at == SETUP, "R4", "ce setup cycles", cyc - ce_at, SETUP);
      end
      if (p_str && !s) chk(cyc - str_at == STROBE, "R4", "strobe width", cyc - str_at, STROBE);
      p_ce  = fl_ce_n;
      p_str = s;
    end
  end

  // result monitor (R12)
  always @(negedge clk) begin
    if (!rst && done_valid) begin
      chk(req_ready == 1'b1, "R12", "ready with done", int'(req_ready), 1);
      if (res_q.size() == 0) chk(0, cur_tag, "unexpected done", 1, 0);
      else begin
        bit e;
        e = res_q.pop_front();
        chk(done_fail == e, cur_tag, "done_fail", int'(done_fail), int'(e));
      end
    end
  end

  task automatic push_wr(input logic [AW-1:0] a, input logic [7:0] d);
    wr_t e;
    e.a = a; e.d = d;
    wr_q.push_back(e);
  endtask

  // driver: pushes expected writes and result, then issues the request
  task automatic run_op(input logic [1:0] op, input logic [AW-1:0] a,
                        input logic [7:0] d, input bit tg, input int busy,
                        input int em, input logic [7:0] rv, input bit exp_fail,
                        input string tag);
    cur_tag = tag;
    push_wr(20'h555, 8'hAA);
    push_wr(20'h2AA, 8'h55);
    if (op == 2'd0) begin
      push_wr(20'h555, 8'hA0);   // R1
      push_wr(a, d);
    end else begin
      push_wr(20'h555, 8'h80);
      push_wr(20'h555, 8'hAA);
      push_wr(20'h2AA, 8'h55);
      if (op == 2'd2) push_wr(a, 8'h30);        // R3
      else            push_wr(20'h555, 8'h10);  // R2
    end
    if (exp_fail) push_wr('0, 8'hF0);           // R11
    res_q.push_back(exp_fail);
    k_busy = busy; k_err = em; k_ready = rv;
    k_tgt7 = (op == 2'd0) ? d[7] : 1'b1;
    exp_rd_addr = a;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_data = d; req_toggle = tg;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R12", "ready drops after accept", int'(req_ready), 0);
    while (res_q.size() != 0) @(negedge clk);
    chk(wr_q.size() == 0, tag, "writes left over", wr_q.size(), 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    chk(req_ready == 1'b1, "R12", "reset ready", int'(req_ready), 1);
    chk(done_valid == 1'b0, "R12", "reset done", int'(done_valid), 0);
    chk(fl_ce_n && fl_we_n && fl_oe_n, "R12", "reset bus idle", 0, 1);

    run_op(2'd0, 20'h01234, 8'h5A, 0, 3, 0, 8'h5A, 0, "R1");   // R1 R5 bit7=0
    run_op(2'd0, 20'h04321, 8'hC3, 0, 2, 0, 8'hC3, 0, "R5");   // bit7=1
    run_op(2'd0, 20'h00042, 8'h96, 0, 3, 1, 8'h96, 0, "R6");   // transient error ok
    run_op(2'd0, 20'h00077, 8'h11, 0, 0, 2, 8'h11, 1, "R6");   // stuck error -> fail, R11
    run_op(2'd1, 20'h10000, 8'h00, 0, 4, 0, 8'hFF, 0, "R2");   // chip erase + R9 verify
    run_op(2'd2, 20'h7A000, 8'h00, 1, 4, 0, 8'hFF, 0, "R3");   // sector erase, R7 toggle
    run_op(2'd2, 20'h3C000, 8'h00, 1, 2, 1, 8'hFF, 0, "R8");   // toggle transient ok
    run_op(2'd0, 20'h00100, 8'h24, 1, 0, 2, 8'h24, 1, "R8");   // toggle stuck -> fail
    run_op(2'd1, 20'h20000, 8'h00, 0, 2, 0, 8'hFE, 1, "R9");   // verify mismatch -> fail
    run_op(2'd0, 20'h00200, 8'h33, 0, 1000, 0, 8'h33, 1, "R10"); // watchdog -> fail
    run_op(2'd0, 20'h00300, 8'h3C, 1, 5, 0, 8'h3C, 0, "R7");   // toggle program
    run_op(2'd3, 20'h30000, 8'h00, 0, 1, 0, 8'hFF, 0, "R2");   // code 3 as chip erase

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule